// File: doc/BRIEF.md
# Pitched Rectangle Copy Engine

This block moves a rectangle of pixels from one surface held in byte-addressed memory to another. Each surface is described by a base offset and a pitch (bytes from one row to the next). Software programs the engine through a method port. Each method write carries a small method code and a 32-bit parameter. Writing the rectangle size is the command that launches the copy.

Once started, the engine first validates the setup in a single cycle. It checks the operation code, the pixel format, both base offsets against their region limits, and whether a row fits in the internal line buffer. If any check fails, it raises an error pulse and touches no memory. Otherwise it walks the rectangle from the top row to the bottom. For each row it reads every byte into a line buffer, then writes the whole row to the destination. This keeps copies within a row correct when the source and destination areas overlap.

The memory port carries one byte per access, and read data returns one cycle after the request. While a copy runs, the method port is held off, and a one-cycle done pulse marks the end of the copy.

Top module: `rcopy_engine`

## Requirements
- R1: Method codes and their fields are as follows.
  - 0 holds the source offset and 1 the destination offset.
  - 2 holds the pitches: source pitch in bits 15:0, destination pitch in bits 31:16.
  - 3 holds the format code in bits 7:0, and 4 holds the operation code.
  - 5 holds the source corner and 6 the destination corner, each with x in bits 15:0 and y in bits 31:16.
  - 7 holds the size: width in bits 15:0, height in bits 31:16.
  - 8 holds the source region limit and 9 the destination region limit.
  - Row r reads from byte address source_offset + (src_y + r) * source_pitch + src_x * bpp, and writes to the same expression built from the destination fields. Bytes outside the rectangle stay unchanged.
- R2: A method write is accepted when m_valid and m_ready are both high. An accepted size write raises busy on the next cycle. Busy stays high, and m_ready low, until the cycle in which done or err is raised. A method presented while busy is ignored.
- R3: If the operation code is not 3 when a copy starts, err is raised and there is no memory access.
- R4: Format code 0x01 selects 1 byte per pixel and 0x0A selects 4 bytes per pixel. Any other format code raises err with no memory access.
- R5: A source offset not below the source limit, or a destination offset not below the destination limit, raises err with no memory access. An offset one below its limit is accepted.
- R6: If the width or the height is zero and all other checks pass, done is raised with no memory access.
- R7: The copy has the following cycle structure.
  - Rows run from top to bottom.
  - Each row issues width * bpp reads, then one idle cycle, then width * bpp writes.
  - A copy takes 1 + height * (2 * width * bpp + 1) cycles from the cycle after the size write to done. This makes copies correct when the destination overlaps the same row of the source.
- R8: done and err are each single-cycle pulses, never high together. done follows the final write by one cycle.
- R9: If a row holds more than BUF_BYTES bytes (default 64), err is raised with no memory access. A row of exactly BUF_BYTES bytes is copied.
- R10: After reset busy, done, err, mem_rd and mem_wr are low and m_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_valid | input | 1 | Method write request |
| m_ready | output | 1 | Method write accepted when high |
| m_code | input | 4 | Method code |
| m_data | input | 32 | Method parameter |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when a copy completes |
| err | output | 1 | One-cycle pulse when a copy is rejected |

## Verification
The bound checker watches the handshake and pulse discipline on every cycle:
- an accepted size write raising busy;
- m_ready being low while busy;
- busy ending only with done or err;
- single-cycle, mutually exclusive done and err;
- memory traffic only while busy, and never a read and a write together.

Whether the right bytes land at the right addresses needs the bench's scenarios. These include the pitched address formula, 1-byte and 4-byte pixels, in-row overlap, rejection of bad codes and offsets, zero-sized and buffer-sized rows, and the exact cycle count of a copy.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;

    localparam logic [3:0] MC_SRC_OFS = 4'd0;
    localparam logic [3:0] MC_DST_OFS = 4'd1;
    localparam logic [3:0] MC_PITCH   = 4'd2;
    localparam logic [3:0] MC_FMT     = 4'd3;
    localparam logic [3:0] MC_OPER    = 4'd4;
    localparam logic [3:0] MC_PT_SRC  = 4'd5;
    localparam logic [3:0] MC_PT_DST  = 4'd6;
    localparam logic [3:0] MC_SIZE    = 4'd7;
    localparam logic [3:0] MC_SRC_LIM = 4'd8;
    localparam logic [3:0] MC_DST_LIM = 4'd9;

    localparam logic [31:0] OPER_COPY = 32'd3;
    localparam logic [7:0]  FMT_BYTE  = 8'h01;
    localparam logic [7:0]  FMT_WORD  = 8'h0A;

    typedef struct packed {
        logic [31:0] src_ofs;
        logic [31:0] dst_ofs;
        logic [31:0] src_lim;
        logic [31:0] dst_lim;
        logic [31:0] oper;
        logic [7:0]  fmt;
        logic [15:0] src_pitch;
        logic [15:0] dst_pitch;
        logic [15:0] src_x;
        logic [15:0] src_y;
        logic [15:0] dst_x;
        logic [15:0] dst_y;
        logic [15:0] width;
        logic [15:0] height;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_READ  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_WRITE = 3'd4
    } st_e;

endpackage

// File: rtl/rcopy_regs.sv
module rcopy_regs
    import rcopy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  code,
    input  logic [31:0] data,
    output cfg_t        cfg,
    output logic        start
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (code)
                MC_SRC_OFS: cfg_d.src_ofs = data;
                MC_DST_OFS: cfg_d.dst_ofs = data;
                MC_PITCH: begin
                    cfg_d.src_pitch = data[15:0];
                    cfg_d.dst_pitch = data[31:16];
                end
                MC_FMT:     cfg_d.fmt  = data[7:0];
                MC_OPER:    cfg_d.oper = data;
                MC_PT_SRC: begin
                    cfg_d.src_x = data[15:0];
                    cfg_d.src_y = data[31:16];
                end
                MC_PT_DST: begin
                    cfg_d.dst_x = data[15:0];
                    cfg_d.dst_y = data[31:16];
                end
                MC_SIZE: begin
                    cfg_d.width  = data[15:0];
                    cfg_d.height = data[31:16];
                end
                MC_SRC_LIM: cfg_d.src_lim = data;
                MC_DST_LIM: cfg_d.dst_lim = data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign start = we && (code == MC_SIZE);

endmodule

// File: rtl/rcopy_linebuf.sv
module rcopy_linebuf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [DEPTH-1:0][7:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (we) line_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign rdata = line_q[raddr];

endmodule

// File: rtl/rcopy_engine.sv
module rcopy_engine
    import rcopy_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        m_valid,
    output logic        m_ready,
    input  logic [3:0]  m_code,
    input  logic [31:0] m_data,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        err
);

    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int NB_W  = 18;

    typedef struct packed {
        st_e              st;
        logic [15:0]      row;
        logic [IDX_W-1:0] col;
        logic [IDX_W:0]   nb;
        logic [31:0]      sbase;
        logic [31:0]      dbase;
        logic             pend;
        logic [IDX_W-1:0] pidx;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cfg_t cfg;
    logic start;
    logic [7:0] lb_rdata;

    // Method port: accepted only while idle.
    logic m_accept;
    assign m_accept = m_valid && (ctl_q.st == ST_IDLE);

    rcopy_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (m_accept),
        .code  (m_code),
        .data  (m_data),
        .cfg   (cfg),
        .start (start)
    );

    rcopy_linebuf #(.DEPTH(BUF_BYTES)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_q.pend),
        .waddr (ctl_q.pidx),
        .wdata (mem_rdata),
        .raddr (ctl_q.col),
        .rdata (lb_rdata)
    );

    // Setup decode used in the check cycle.
    logic [1:0]      px_sh;
    logic            fmt_ok;
    logic [NB_W-1:0] nb_full;
    logic [31:0]     sbase_c, dbase_c;
    logic            col_last, row_last;

    always_comb begin
        fmt_ok = 1'b1;
        px_sh  = 2'd0;
        if (cfg.fmt == FMT_WORD)      px_sh = 2'd2;
        else if (cfg.fmt != FMT_BYTE) fmt_ok = 1'b0;
        nb_full = {2'b00, cfg.width} << px_sh;
        sbase_c = cfg.src_ofs + (32'(cfg.src_y) * 32'(cfg.src_pitch))
                + (32'(cfg.src_x) << px_sh);
        dbase_c = cfg.dst_ofs + (32'(cfg.dst_y) * 32'(cfg.dst_pitch))
                + (32'(cfg.dst_x) << px_sh);
    end

    assign col_last = ({1'b0, ctl_q.col} == (ctl_q.nb - 1'b1));
    assign row_last = (ctl_q.row == (cfg.height - 16'd1));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        ctl_d.pend = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) ctl_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                ctl_d.st = ST_IDLE;
                if (cfg.oper != OPER_COPY || !fmt_ok
                    || cfg.src_ofs >= cfg.src_lim
                    || cfg.dst_ofs >= cfg.dst_lim) begin
                    ctl_d.err = 1'b1;
                end else if (cfg.width == 16'd0 || cfg.height == 16'd0) begin
                    ctl_d.done = 1'b1;
                end else if (nb_full > NB_W'(BUF_BYTES)) begin
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.st    = ST_READ;
                    ctl_d.row   = '0;
                    ctl_d.col   = '0;
                    ctl_d.nb    = nb_full[IDX_W:0];
                    ctl_d.sbase = sbase_c;
                    ctl_d.dbase = dbase_c;
                end
            end
            ST_READ: begin
                ctl_d.pend = 1'b1;
                ctl_d.pidx = ctl_q.col;
                if (col_last) begin
                    ctl_d.col = '0;
                    ctl_d.st  = ST_WAIT;
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
            end
            ST_WAIT: begin
                ctl_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (col_last) begin
                    ctl_d.col = '0;
                    if (row_last) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st    = ST_READ;
                        ctl_d.row   = ctl_q.row + 16'd1;
                        ctl_d.sbase = ctl_q.sbase + 32'(cfg.src_pitch);
                        ctl_d.dbase = ctl_q.dbase + 32'(cfg.dst_pitch);
                    end
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_rd    = (ctl_q.st == ST_READ);
    assign mem_wr    = (ctl_q.st == ST_WRITE);
    assign mem_addr  = mem_rd ? (ctl_q.sbase + 32'(ctl_q.col))
                     : mem_wr ? (ctl_q.dbase + 32'(ctl_q.col)) : 32'd0;
    assign mem_wdata = mem_wr ? lb_rdata : 8'd0;
    assign busy      = (ctl_q.st != ST_IDLE);
    assign m_ready   = (ctl_q.st == ST_IDLE);
    assign done      = ctl_q.done;
    assign err       = ctl_q.err;

endmodule

// File: rtl/rcopy_engine_chk.sv
module rcopy_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       m_valid,
    input logic       m_ready,
    input logic [3:0] m_code,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       busy,
    input logic       done,
    input logic       err
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_code == 4'd7) |=> busy);

    // R2
    busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !m_ready);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R3
    traffic_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind rcopy_engine rcopy_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_code  (m_code),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .busy    (busy),
    .done    (done),
    .err     (err)
);

// File: tb/rcopy_engine_test.sv
`timescale 1ns/1ps
module rcopy_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic [3:0]  m_code = '0;
    logic [31:0] m_data = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0;

    logic [7:0] mem [0:4095];

    always #2.5 clk = ~clk;

    rcopy_engine uut (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
        .m_code(m_code), .m_data(m_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (mem_rd) rd_cnt++;
        if (mem_wr) wr_cnt++;
        if (done)   done_cnt++;
        if (err)    err_cnt++;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    endtask

    task automatic mwrite(input logic [3:0] c, input logic [31:0] d);
        @(negedge clk);
        while (!m_ready) @(negedge clk);
        m_valid = 1'b1; m_code = c; m_data = d;
        @(negedge clk);
        m_valid = 1'b0;
    endtask

    task automatic setup(input int so, input int dso, input int sl, input int dl,
                         input int op, input int fmt, input int sp, input int dp,
                         input int sx, input int sy, input int dx, input int dy);
        mwrite(4'd0, 32'(so));
        mwrite(4'd1, 32'(dso));
        mwrite(4'd8, 32'(sl));
        mwrite(4'd9, 32'(dl));
        mwrite(4'd4, 32'(op));
        mwrite(4'd3, 32'(fmt));
        mwrite(4'd2, {16'(dp), 16'(sp)});
        mwrite(4'd5, {16'(sy), 16'(sx)});
        mwrite(4'd6, {16'(dy), 16'(dx)});
    endtask

    // Starts a copy and waits for done/err; returns cycles and busy gaps.
    task automatic run(input int w, input int h, output int cyc, output int gap);
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
        mwrite(4'd7, {16'(h), 16'(w)});
        cyc = 0; gap = 0;
        while (!(done || err) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (!busy && !(done || err)) gap++;
        end
        @(negedge clk);
    endtask

    task automatic check_rect(input string req, input int sb, input int sp,
                              input int db, input int dp, input int nb, input int h);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int r = 0; r < h; r++)
            for (int b = 0; b < nb; b++)
                if (mem[db + r*dp + b] !== pat(sb + r*sp + b)) begin
                    if (bad == 0) begin
                        first_act = int'(mem[db + r*dp + b]);
                        first_exp = int'(pat(sb + r*sp + b));
                    end
                    bad++;
                end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R10 status", {busy, done, err}, 0);
        chk(!mem_rd && !mem_wr, "R10 mem idle", {mem_rd, mem_wr}, 0);
        chk(m_ready, "R10 ready", m_ready, 1);
    endtask

    task automatic t_byte_copy();
        int cyc, gap;
        init_mem();
        setup('h100, 'h400, 'h1000, 'h1000, 3, 'h01, 16, 32, 2, 1, 3, 2);
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
        mwrite(4'd7, {16'd3, 16'd5});
        chk(busy && !m_ready, "R2 busy after start", {busy, m_ready}, 2);
        cyc = 0; gap = 0;
        while (!(done || err) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (!busy && !(done || err)) gap++;
        end
        @(negedge clk);
        chk(gap == 0, "R2 busy held", gap, 0);
        chk(cyc == 34, "R7 copy cycles", cyc, 34);
        chk(done_cnt == 1 && err_cnt == 0, "R8 single done", done_cnt, 1);
        chk(rd_cnt == 15 && wr_cnt == 15, "R1 access count", wr_cnt, 15);
        check_rect("R1 byte copy", 'h100 + 16 + 2, 16, 'h400 + 64 + 3, 32, 5, 3);
        chk(mem['h400 + 64 + 2] == pat('h400 + 64 + 2), "R1 left edge untouched",
            mem['h400 + 64 + 2], pat('h400 + 64 + 2));
        chk(mem['h400 + 64 + 8] == pat('h400 + 64 + 8), "R1 right edge untouched",
            mem['h400 + 64 + 8], pat('h400 + 64 + 8));
        chk(mem['h400 + 5*32 + 3] == pat('h400 + 5*32 + 3), "R1 row below untouched",
            mem['h400 + 5*32 + 3], pat('h400 + 5*32 + 3));
    endtask

    task automatic t_ignore_busy();
        int cyc, gap;
        mwrite(4'd1, 32'h600);
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
        mwrite(4'd7, {16'd3, 16'd5});
        m_valid = 1'b1; m_code = 4'd0; m_data = 32'h300;
        @(negedge clk);
        m_valid = 1'b0;
        cyc = 0;
        while (!(done || err) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        check_rect("R2 write while busy ignored", 'h100 + 16 + 2, 16, 'h600 + 64 + 3, 32, 5, 3);
        // a second run from the unchanged source offset
        rd_cnt = 0;
        run(1, 1, cyc, gap);
        chk(mem['h600 + 64 + 3] == pat('h100 + 16 + 2), "R2 source offset kept",
            mem['h600 + 64 + 3], pat('h100 + 16 + 2));
    endtask

    task automatic t_word_copy();
        int cyc, gap;
        init_mem();
        setup('h200, 'h500, 'h1000, 'h1000, 3, 'h0A, 40, 48, 1, 2, 2, 0);
        run(3, 2, cyc, gap);
        chk(done_cnt == 1 && wr_cnt == 24, "R4 four-byte writes", wr_cnt, 24);
        chk(cyc == 1 + 2*25, "R7 word copy cycles", cyc, 51);
        check_rect("R4 four-byte copy", 'h200 + 80 + 4, 40, 'h500 + 8, 48, 12, 2);
        chk(mem['h500 + 20] == pat('h500 + 20), "R4 past row end untouched",
            mem['h500 + 20], pat('h500 + 20));
    endtask

    task automatic t_overlap();
        int cyc, gap;
        init_mem();
        setup('h800, 'h800, 'h1000, 'h1000, 3, 'h01, 16, 16, 0, 0, 1, 0);
        run(8, 2, cyc, gap);
        chk(done_cnt == 1, "R7 overlap done", done_cnt, 1);
        check_rect("R7 in-row overlap", 'h800, 16, 'h801, 16, 8, 2);
    endtask

    task automatic t_bad_op();
        int cyc, gap;
        init_mem();
        setup('h100, 'h400, 'h1000, 'h1000, 2, 'h01, 16, 16, 0, 0, 0, 0);
        run(4, 4, cyc, gap);
        chk(err_cnt == 1 && done_cnt == 0, "R3 bad op err", err_cnt, 1);
        chk(rd_cnt == 0 && wr_cnt == 0, "R3 no traffic", rd_cnt + wr_cnt, 0);
        chk(mem['h400] == pat('h400), "R3 dest unchanged", mem['h400], pat('h400));
    endtask

    task automatic t_bad_fmt();
        int cyc, gap;
        setup('h100, 'h400, 'h1000, 'h1000, 3, 'h05, 16, 16, 0, 0, 0, 0);
        run(4, 4, cyc, gap);
        chk(err_cnt == 1 && done_cnt == 0, "R4 bad format err", err_cnt, 1);
        chk(rd_cnt == 0 && wr_cnt == 0, "R4 no traffic", rd_cnt + wr_cnt, 0);
    endtask

    task automatic t_bounds();
        int cyc, gap;
        init_mem();
        setup('h100, 'h400, 'h100, 'h1000, 3, 'h01, 16, 16, 0, 0, 0, 0);
        run(2, 1, cyc, gap);
        chk(err_cnt == 1 && rd_cnt + wr_cnt == 0, "R5 source at limit", err_cnt, 1);
        mwrite(4'd8, 32'h1000);
        mwrite(4'd9, 32'h400);
        run(2, 1, cyc, gap);
        chk(err_cnt == 1 && rd_cnt + wr_cnt == 0, "R5 dest at limit", err_cnt, 1);
        mwrite(4'd8, 32'h101);
        mwrite(4'd9, 32'h401);
        run(2, 1, cyc, gap);
        chk(done_cnt == 1 && err_cnt == 0 && wr_cnt == 2, "R5 one below limit", wr_cnt, 2);
    endtask

    task automatic t_zero();
        int cyc, gap;
        setup('h100, 'h400, 'h1000, 'h1000, 3, 'h01, 16, 16, 0, 0, 0, 0);
        run(0, 3, cyc, gap);
        chk(done_cnt == 1 && err_cnt == 0 && cyc == 1, "R6 zero width done", cyc, 1);
        chk(rd_cnt + wr_cnt == 0, "R6 zero width no traffic", rd_cnt + wr_cnt, 0);
        run(3, 0, cyc, gap);
        chk(done_cnt == 1 && rd_cnt + wr_cnt == 0, "R6 zero height", rd_cnt + wr_cnt, 0);
    endtask

    task automatic t_buffer();
        int cyc, gap;
        init_mem();
        setup('h000, 'hC00, 'h1000, 'h1000, 3, 'h0A, 64, 64, 0, 0, 0, 0);
        run(16, 1, cyc, gap);
        chk(done_cnt == 1 && wr_cnt == 64, "R9 full buffer row", wr_cnt, 64);
        check_rect("R9 full buffer data", 'h000, 64, 'hC00, 64, 64, 1);
        run(17, 1, cyc, gap);
        chk(err_cnt == 1 && rd_cnt + wr_cnt == 0, "R9 oversize row err", err_cnt, 1);
    endtask

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_copy();
        t_ignore_busy();
        t_word_copy();
        t_overlap();
        t_bad_op();
        t_bad_fmt();
        t_bounds();
        t_zero();
        t_buffer();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule